// File: doc/BRIEF.md
# Serial Memory Target Engine (two-wire bus, byte-addressed array)

This block is the protocol engine of a two-wire (I2C) target that fronts a byte-addressed non-volatile array. It watches the bus lines through synchronisers on a system clock that runs at least eight times faster than SCL. It finds bus conditions, answers to its own seven-bit address, and takes a two-byte memory pointer. It then loads data bytes into an external page buffer, or returns array bytes to the master. It pulls SDA low only through an open-drain enable, and it never holds SCL.

Writes reach the page buffer as one strobe per byte, each with its full target address. A STOP that ends a write with loaded data raises a single commit strobe. The storage side then reports an internal write cycle on `mem_busy`. While that cycle runs, the engine ignores its own address, so a master can poll for completion by repeating its request until it is acknowledged. Reads use one internal pointer. It advances after every byte sent and wraps from the top of the array to zero. After a page write, the pointer stays inside the page that was written.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, `sda_oe`, `buf_load` and `buf_commit` are low, and the internal pointer on `rd_addr` is 0.
- R2: Until a START is seen (SDA falls while SCL is high), clocked bytes are ignored and never acknowledged.
- R3: The first byte after a START is the select byte. Bits 7..4 must be 4'b1010 and bits 3..1 must equal `dev_sel`. Bit 0 is 1 for read and 0 for write. On a match the engine drives SDA low during the ninth clock. On a mismatch it stays silent and ignores the bus until the next START.
- R4: The engine samples SDA on a rising edge of SCL. It changes `sda_oe` only after a falling edge of SCL, never while SCL is high.
- R5: A write sends the pointer high byte, then the low byte, then data bytes, and each byte is acknowledged. High-byte bits at or above ADDR_W-8 are ignored. Each data byte gives one `buf_load` pulse with its address and value. A later STOP gives exactly one `buf_commit` pulse, and never in the same cycle as a load.
- R6: While `mem_busy` is high, a matching select byte is not acknowledged.
- R7: `wr_lock` is captured on the SCL falling edge that ends the acknowledge of the low pointer byte. If it was high, the first data byte is not acknowledged, nothing is loaded and no commit follows. A change of `wr_lock` after that edge has no effect on the transfer.
- R8: Consecutive data bytes advance only the low PAGE_W pointer bits, wrapping to the start of the same page. After the write, the pointer is one past the last loaded byte within that page.
- R9: A read with no pointer bytes returns the byte at the internal pointer, MSB first.
- R10: Pointer bytes sent in write mode, then a repeated START and a read select byte, make the read start at the new pointer, with nothing written.
- R11: Each master ACK after a read byte makes the engine send the next byte. The pointer crosses page borders freely and wraps from 2^ADDR_W-1 to 0.
- R12: A master NACK ends the read. SDA is released and further clocks are ignored until a START.
- R13: A START in the middle of a byte abandons it and restarts select-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level, asynchronous |
| sda_i | input | 1 | Bus data level, asynchronous |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| dev_sel | input | 3 | Board-level bits 3..1 of the select byte |
| wr_lock | input | 1 | High blocks writes (synchronous to clk) |
| buf_load | output | 1 | One-cycle strobe: store `buf_data` at `buf_addr` in the page buffer |
| buf_addr | output | ADDR_W | Array address of the loaded byte |
| buf_data | output | 8 | Loaded byte value |
| buf_commit | output | 1 | One-cycle strobe: start the internal write cycle |
| mem_busy | input | 1 | Internal write cycle in progress |
| rd_addr | output | ADDR_W | Internal pointer, array read address |
| rd_data | input | 8 | Array byte at `rd_addr`, valid within two clocks |

## Verification
The assertions take four things for granted about the inputs. Each SCL level lasts at least four system clocks. The master changes SDA only while SCL is low, except when it makes a START or a STOP. `rd_data` follows `rd_addr` within two cycles. `mem_busy` comes only from the storage side. The stimulus holds each quarter of an SCL period for six clocks and changes every bus line on the falling clock edge. Data changes always fall inside SCL-low phases. The read port is a combinational array model, and busy is a counter started by the commit strobe that runs far longer than one select byte.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam logic [3:0] SEL_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEL  = 3'd1,
        ST_PHI  = 3'd2,
        ST_PLO  = 3'd3,
        ST_WDAT = 3'd4,
        ST_RDAT = 3'd5
    } smt_state_e;

endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now_s,
    output logic [LINES-1:0] prev_s
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign now_s[i]  = chain_q[STAGES-1];
        assign prev_s[i] = chain_q[STAGES];
    end

endmodule

// File: rtl/smt_bus_cond.sv
module smt_bus_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    always_comb begin
        ev_start = scl_now & scl_prev & sda_prev & ~sda_now;
        ev_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
        ev_rise  = scl_now & ~scl_prev;
        ev_fall  = ~scl_now & scl_prev;
    end

endmodule

// File: rtl/smt_addr_ctr.sv
module smt_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [ADDR_W-9:0] hi_bits,
    input  logic [7:0]        lo_bits,
    input  logic              step_page,
    input  logic              step_all,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] page_next;

    if (PAGE_W >= ADDR_W) begin : g_flat
        assign page_next = addr_q + 1'b1;
    end else begin : g_paged
        assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
    end

    always_comb begin
        addr_d = addr_q;
        if (ld_hi)          addr_d[ADDR_W-1:8] = hi_bits;
        else if (ld_lo)     addr_d[7:0]        = lo_bits;
        else if (step_page) addr_d             = page_next;
        else if (step_all)  addr_d             = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    if (PAGE_W < ADDR_W) begin : g_chk_page
        AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n) step_page |=> $stable(addr_q[ADDR_W-1:PAGE_W])); // R8
    end
    AST_TOP_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (step_all && !step_page && !ld_hi && !ld_lo && (&addr_q)) |=> (addr_q == '0)); // R11

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PAGE_W    = 5,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              wr_lock,
    output logic              buf_load,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              buf_commit,
    input  logic              mem_busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);

    localparam int          HI_W     = ADDR_W - 8;
    localparam logic [3:0]  ACK_SLOT = 4'd8;
    localparam logic [3:0]  ACK_HIGH = 4'd9;

    typedef struct packed {
        smt_state_e        state;
        logic [3:0]        cnt;
        logic [7:0]        sr;
        logic [7:0]        tx;
        logic              oe;
        logic              rd;
        logic              mack;
        logic              wp;
        logic              dirty;
        logic              load;
        logic              commit;
        logic [7:0]        ld_data;
        logic [ADDR_W-1:0] ld_addr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic scl_s, scl_p, sda_s, sda_p;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic ld_hi, ld_lo, step_page, step_all;
    logic [ADDR_W-1:0] ptr;
    logic sel_hit;

    smt_line_sync #(.LINES(2), .STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({scl_i, sda_i}),
        .now_s  ({scl_s, sda_s}),
        .prev_s ({scl_p, sda_p})
    );

    smt_bus_cond u_cond (
        .scl_now  (scl_s),
        .scl_prev (scl_p),
        .sda_now  (sda_s),
        .sda_prev (sda_p),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    smt_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_hi     (ld_hi),
        .ld_lo     (ld_lo),
        .hi_bits   (eng_q.sr[HI_W-1:0]),
        .lo_bits   (eng_q.sr),
        .step_page (step_page),
        .step_all  (step_all),
        .addr      (ptr)
    );

    assign sel_hit = (eng_q.sr[7:4] == SEL_TAG) && (eng_q.sr[3:1] == dev_sel) && !mem_busy;

    always_comb begin
        eng_d        = eng_q;
        eng_d.load   = 1'b0;
        eng_d.commit = 1'b0;
        ld_hi        = 1'b0;
        ld_lo        = 1'b0;
        step_page    = 1'b0;
        step_all     = 1'b0;

        if (ev_start) begin
            eng_d.state = ST_SEL;
            eng_d.cnt   = '0;
            eng_d.oe    = 1'b0;
        end else if (ev_stop) begin
            eng_d.state = ST_IDLE;
            eng_d.cnt   = '0;
            eng_d.oe    = 1'b0;
            if (eng_q.dirty) begin
                eng_d.commit = 1'b1;
                eng_d.dirty  = 1'b0;
            end
        end else if (eng_q.state != ST_IDLE) begin
            if (ev_rise) begin
                if (eng_q.cnt < ACK_SLOT) begin
                    eng_d.cnt = eng_q.cnt + 4'd1;
                    if (eng_q.state != ST_RDAT) eng_d.sr = {eng_q.sr[6:0], sda_s};
                end else if (eng_q.cnt == ACK_HIGH && eng_q.state == ST_RDAT) begin
                    eng_d.mack = !sda_s;
                end
            end else if (ev_fall) begin
                if (eng_q.state == ST_RDAT) begin
                    if (eng_q.cnt != 4'd0 && eng_q.cnt < ACK_SLOT) begin
                        eng_d.tx = {eng_q.tx[6:0], eng_q.tx[7]};
                        eng_d.oe = !eng_q.tx[6];
                    end else if (eng_q.cnt == ACK_SLOT) begin
                        eng_d.oe  = 1'b0;
                        eng_d.cnt = ACK_HIGH;
                        step_all  = 1'b1;
                    end else if (eng_q.cnt == ACK_HIGH) begin
                        eng_d.cnt = '0;
                        if (eng_q.mack) begin
                            eng_d.tx = rd_data;
                            eng_d.oe = !rd_data[7];
                        end else begin
                            eng_d.state = ST_IDLE;
                            eng_d.oe    = 1'b0;
                        end
                    end
                end else if (eng_q.cnt == ACK_SLOT) begin
                    eng_d.cnt = ACK_HIGH;
                    case (eng_q.state)
                        ST_SEL: begin
                            if (sel_hit) begin
                                eng_d.oe = 1'b1;
                                eng_d.rd = eng_q.sr[0];
                            end else begin
                                eng_d.state = ST_IDLE;
                                eng_d.cnt   = '0;
                            end
                        end
                        ST_PHI: begin
                            eng_d.oe = 1'b1;
                            ld_hi    = 1'b1;
                        end
                        ST_PLO: begin
                            eng_d.oe = 1'b1;
                            ld_lo    = 1'b1;
                        end
                        ST_WDAT: begin
                            if (eng_q.wp) begin
                                eng_d.state = ST_IDLE;
                                eng_d.cnt   = '0;
                            end else begin
                                eng_d.oe      = 1'b1;
                                eng_d.load    = 1'b1;
                                eng_d.ld_addr = ptr;
                                eng_d.ld_data = eng_q.sr;
                                eng_d.dirty   = 1'b1;
                                step_page     = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end else if (eng_q.cnt == ACK_HIGH) begin
                    eng_d.oe  = 1'b0;
                    eng_d.cnt = '0;
                    case (eng_q.state)
                        ST_SEL: begin
                            if (eng_q.rd) begin
                                eng_d.state = ST_RDAT;
                                eng_d.tx    = rd_data;
                                eng_d.oe    = !rd_data[7];
                            end else begin
                                eng_d.state = ST_PHI;
                            end
                        end
                        ST_PHI: eng_d.state = ST_PLO;
                        ST_PLO: begin
                            eng_d.state = ST_WDAT;
                            eng_d.wp    = wr_lock;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sda_oe     = eng_q.oe;
    assign buf_load   = eng_q.load;
    assign buf_addr   = eng_q.ld_addr;
    assign buf_data   = eng_q.ld_data;
    assign buf_commit = eng_q.commit;
    assign rd_addr    = ptr;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (eng_q.state == ST_IDLE) |-> !sda_oe); // R12
    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(ev_fall)); // R4
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (eng_q.state == ST_SEL && eng_q.cnt == ACK_SLOT && ev_fall && mem_busy) |=> !sda_oe); // R6
    AST_LOCK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) buf_load |-> !eng_q.wp); // R7
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) buf_commit |-> $past(ev_stop)); // R5
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n) !(buf_load && buf_commit)); // R5

endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;

    localparam int AW = 10;
    localparam int PW = 5;
    localparam int NB = 1 << AW;
    localparam int PG = 1 << PW;
    localparam int Q  = 6;
    localparam int BUSY_CLKS = 600;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          wr_lock = 1'b0;
    logic [2:0]    dev_sel = 3'b101;
    logic          sda_oe, buf_load, buf_commit, mem_busy;
    logic [AW-1:0] buf_addr, rd_addr;
    logic [7:0]    buf_data, rd_data;
    wire           sda_bus = sda_m & ~sda_oe;

    logic [7:0] mem   [NB];
    logic [7:0] pend  [NB];
    logic       pend_v[NB];
    logic [7:0] exp_m [NB];
    int busy_cnt = 0;
    int n_loads = 0;
    int n_commits = 0;
    logic [AW-1:0] ld_a [64];
    logic [7:0]    ld_d [64];
    int n_chk = 0;
    int n_bad = 0;
    int oe_viol = 0;
    int cyc = 0;
    logic [AW-1:0] cur = '0;
    logic prev_oe = 1'b0;

    assign mem_busy = (busy_cnt != 0);
    assign rd_data  = mem[rd_addr];

    serial_mem_target #(.ADDR_W(AW), .PAGE_W(PW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .dev_sel    (dev_sel),
        .wr_lock    (wr_lock),
        .buf_load   (buf_load),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .buf_commit (buf_commit),
        .mem_busy   (mem_busy),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // storage-side model: page buffer, array, busy timer
    always @(posedge clk) begin
        if (buf_load) begin
            pend[buf_addr]   = buf_data;
            pend_v[buf_addr] = 1'b1;
            ld_a[n_loads % 64] = buf_addr;
            ld_d[n_loads % 64] = buf_data;
            n_loads++;
        end
        if (buf_commit) begin
            for (int i = 0; i < NB; i++) begin
                if (pend_v[i]) begin
                    mem[i]    = pend[i];
                    pend_v[i] = 1'b0;
                end
            end
            busy_cnt = BUSY_CLKS;
            n_commits++;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
    end

    // R4 monitor: the enable must not move while SCL is high
    always @(posedge clk) begin
        if (rst_n && scl_m && (sda_oe !== prev_oe)) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): cycles=%0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pg_step(input logic [AW-1:0] a, input int k);
        logic [AW-1:0] lo;
        lo = a + AW'(k);
        return (a & ~AW'(PG - 1)) | (lo & AW'(PG - 1));
    endfunction

    function automatic logic [7:0] sel_byte(input logic rw);
        return {4'b1010, dev_sel, rw};
    endfunction

    // ---------------- bus master primitives ----------------
    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
        end
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = !sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1;
            wq(); b[i] = sda_bus;
            wq(); scl_m = 1'b0;
        end
        wq(); sda_m = !give_ack;
        wq(); scl_m = 1'b1;
        wq(); wq(); scl_m = 1'b0;
        wq(); sda_m = 1'b1;
    endtask

    // ---------------- composite operations ----------------
    task automatic set_ptr(input logic [AW-1:0] a, input logic [7:0] junk_hi, input string req);
        logic ack;
        bus_start();
        send_byte(sel_byte(1'b0), ack); chk({req, " select ack"}, ack, 1'b1);
        send_byte(junk_hi | 8'(a >> 8), ack); chk({req, " high ptr ack"}, ack, 1'b1);
        send_byte(a[7:0], ack); chk({req, " low ptr ack"}, ack, 1'b1);
    endtask

    task automatic read_out(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(req, b, exp_m[cur]);
            cur = cur + 1'b1;
        end
    endtask

    task automatic sel_read(input logic [AW-1:0] a, input int n, input string req);
        logic ack;
        set_ptr(a, 8'h00, req);
        bus_start();
        send_byte(sel_byte(1'b1), ack); chk({req, " read select ack"}, ack, 1'b1);
        cur = a;
        read_out(n, req);
        bus_stop();
    endtask

    task automatic wait_ready(output int tries);
        logic ack;
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 40) begin
            bus_start();
            send_byte(sel_byte(1'b0), ack);
            bus_stop();
            tries++;
        end
    endtask

    task automatic page_write(input logic [AW-1:0] a, input int n, input logic [31:0] dat,
                              input logic [7:0] junk_hi, input string req);
        logic ack;
        int base;
        int tries;
        base = n_loads;
        set_ptr(a, junk_hi, req);
        for (int i = 0; i < n; i++) begin
            send_byte(dat[8*i +: 8], ack);
            chk({req, " data ack"}, ack, 1'b1);
        end
        bus_stop();
        chk({req, " load count"}, n_loads - base, n);
        for (int i = 0; i < n; i++) begin
            chk({req, " load address"}, ld_a[(base + i) % 64], pg_step(a, i));
            chk({req, " load data"}, ld_d[(base + i) % 64], dat[8*i +: 8]);
            exp_m[pg_step(a, i)] = dat[8*i +: 8];
        end
        cur = pg_step(a, n);
        wait_ready(tries);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe, 1'b0);
        chk("R1 buf_load after reset", buf_load, 1'b0);
        chk("R1 buf_commit after reset", buf_commit, 1'b0);
        chk("R1 pointer after reset", rd_addr, '0);
    endtask

    task automatic t_no_start();
        logic ack;
        scl_m = 1'b0; wq();
        send_byte(sel_byte(1'b0), ack);
        chk("R2 no ack without START", ack, 1'b0);
        bus_stop();
    endtask

    task automatic t_select();
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ack);
        chk("R3 wrong dev_sel bits ignored", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, dev_sel, 1'b0}, ack);
        chk("R3 wrong tag ignored", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(sel_byte(1'b0), ack);
        chk("R3 matching select acknowledged", ack, 1'b1);
        bus_stop();
        chk("R3 no commit after select only", n_commits, 0);
    endtask

    task automatic t_byte_write();
        logic ack;
        int tries;
        int base_c;
        base_c = n_commits;
        set_ptr(10'h105, 8'hFC, "R5");
        send_byte(8'h5A, ack); chk("R5 data ack", ack, 1'b1);
        chk("R5 one load", n_loads, 1);
        chk("R5 load address (high bits ignored)", ld_a[0], 10'h105);
        chk("R5 load data", ld_d[0], 8'h5A);
        chk("R5 no commit before STOP", n_commits, base_c);
        bus_stop();
        chk("R5 one commit after STOP", n_commits, base_c + 1);
        exp_m[10'h105] = 8'h5A;
        cur = 10'h106;
        wait_ready(tries);
        chk("R6 select refused while busy", (tries > 1) ? 1 : 0, 1);
        chk("R6 select accepted when idle", (tries < 40) ? 1 : 0, 1);
    endtask

    task automatic t_cur_read();
        logic ack;
        bus_start();
        send_byte(sel_byte(1'b1), ack); chk("R9 read select ack", ack, 1'b1);
        read_out(1, "R9 current-pointer read");
        bus_stop();
    endtask

    task automatic t_page_write();
        logic ack;
        page_write(10'h01E, 4, 32'h44332211, 8'h00, "R8 page write");
        bus_start();
        send_byte(sel_byte(1'b1), ack); chk("R8 read select ack", ack, 1'b1);
        read_out(1, "R8 pointer stays in page after commit");
        bus_stop();
        sel_read(10'h01E, 4, "R10 selective read across page border");
    endtask

    task automatic t_wrap();
        sel_read(10'h3FE, 3, "R11 sequential wrap to zero");
    endtask

    task automatic t_lock();
        logic ack;
        int base_c;
        int base_l;
        int tries;
        base_c = n_commits;
        base_l = n_loads;
        wr_lock = 1'b1;
        set_ptr(10'h200, 8'h00, "R7 locked");
        send_byte(8'h77, ack); chk("R7 locked data refused", ack, 1'b0);
        bus_stop();
        wr_lock = 1'b0;
        chk("R7 nothing loaded", n_loads, base_l);
        chk("R7 nothing committed", n_commits, base_c);
        bus_start();
        send_byte(sel_byte(1'b0), ack); chk("R7 no write cycle started", ack, 1'b1);
        bus_stop();
        sel_read(10'h200, 1, "R7 locked byte unchanged");
        set_ptr(10'h200, 8'h00, "R7 late lock");
        wr_lock = 1'b1;
        send_byte(8'h66, ack); chk("R7 lock after capture edge has no effect", ack, 1'b1);
        bus_stop();
        wr_lock = 1'b0;
        chk("R7 late lock commit", n_commits, base_c + 1);
        exp_m[10'h200] = 8'h66;
        wait_ready(tries);
        sel_read(10'h200, 1, "R7 late lock byte written");
    endtask

    task automatic t_nack_end();
        logic ack;
        logic [7:0] b;
        set_ptr(10'h010, 8'h00, "R12");
        bus_start();
        send_byte(sel_byte(1'b1), ack); chk("R12 read select ack", ack, 1'b1);
        cur = 10'h010;
        read_out(1, "R12 read before NACK");
        recv_byte(1'b0, b);
        chk("R12 bus released after NACK", b, 8'hFF);
        bus_stop();
        chk("R12 enable low after STOP", sda_oe, 1'b0);
    endtask

    task automatic t_restart();
        logic ack;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(sel_byte(1'b1), ack); chk("R13 select after mid-byte START", ack, 1'b1);
        read_out(1, "R13 read after restart");
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            mem[i]    = 8'((i * 37 + 11) & 8'hFF);
            exp_m[i]  = 8'((i * 37 + 11) & 8'hFF);
            pend_v[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_select();
        t_byte_write();
        t_cur_read();
        sel_read(10'h105, 1, "R10 selective read of written byte");
        t_page_write();
        t_wrap();
        t_lock();
        t_nack_end();
        t_restart();
        chk("R4 enable never moved with SCL high", oe_viol, 0);
        summary();
        $finish;
    end

endmodule